// File: doc/BRIEF.md
# Event Gating and I/O Permission Unit

This block sits at the retire point of a processor core. On every instruction-complete strobe it looks at the pending event requests and the current control flags, and it picks at most one event to take. The candidates are an internal fault, a debug fault, a non-maskable interrupt, a single-step trap and a maskable interrupt. The same decision also checks whether a completing I/O instruction is permitted at the current privilege level. It also produces the next value of the restart flag, which decides whether debug faults are taken.

Separately, an interrupt-return strobe is turned into a one-cycle select between the normal return path and a return through a task switch. Every output is registered. A decision made at clock edge N is visible on the outputs during the cycle that follows edge N.

Top module: `evt_gate_unit`

## Requirements
- R1: A maskable request (`req_mask_i`) produces no event while `int_en_i` is 0. With the request held, it is taken at the first decision where `int_en_i` is 1.
- R2: A non-maskable request and an internal fault request are taken whatever the value of `int_en_i`.
- R3: When `trap_flag_i` is 1 and the instruction completes, `step_req_o` pulses. The step event (code 4) is selected when no higher-priority event is pending.
- R4: An I/O instruction (`io_insn_i`=1) is permitted when `cur_lvl_i` is less than or equal to `io_lvl_i`, compared as unsigned values. Otherwise `io_fault_o` pulses and the fault event (code 1) is selected. The instruction then counts as not completed, so `step_req_o` stays 0.
- R5: A debug fault request is rejected when `restart_flag_i` is 1 and accepted when it is 0.
- R6: `rf_o` becomes 1 after a decision that takes a fault-class event (an internal fault or an I/O fault). It becomes 0 after any other decision, and it holds its value between decisions.
- R7: An `iret_i` strobe pulses `ret_norm_o` when `chain_flag_i` is 0 and pulses `ret_task_o` when `chain_flag_i` is 1.
- R8: Priority, from highest to lowest, is fault, debug, non-maskable, step, maskable. `evt_onehot_o` has at most one bit set: bit 0 fault, bit 1 debug, bit 2 non-maskable, bit 3 step, bit 4 maskable. `evt_code_o` is 0 for none and is otherwise the bit index plus 1.
- R9: Decisions are made only on cycles where `insn_done_i` is 1. The event, step and fault outputs are one-cycle pulses in the following cycle and are 0 at all other times.
- R10: While reset is held, and just after it, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| insn_done_i | input | 1 | Instruction-complete strobe; triggers a decision |
| io_insn_i | input | 1 | The completing instruction is an I/O access |
| iret_i | input | 1 | Interrupt-return strobe |
| trap_flag_i | input | 1 | Single-step trap flag |
| int_en_i | input | 1 | Maskable interrupt enable flag |
| restart_flag_i | input | 1 | Restart flag; 1 rejects debug faults |
| chain_flag_i | input | 1 | Nested-task flag used for return-path selection |
| io_lvl_i | input | PRIV_W | I/O privilege threshold |
| cur_lvl_i | input | PRIV_W | Current privilege level |
| req_mask_i | input | 1 | Pending maskable interrupt (level) |
| req_nmi_i | input | 1 | Pending non-maskable interrupt (level) |
| req_fault_i | input | 1 | Pending internal fault |
| req_dbg_i | input | 1 | Pending debug fault |
| evt_onehot_o | output | 5 | Selected event, one-hot |
| evt_code_o | output | 3 | Selected event code |
| step_req_o | output | 1 | Single-step trap request pulse |
| io_fault_o | output | 1 | I/O protection fault pulse |
| ret_norm_o | output | 1 | Normal return path selected |
| ret_task_o | output | 1 | Task-switch return path selected |
| rf_o | output | 1 | Updated restart flag |

## Verification
The arbiter is driven with one request at a time, and then with pairs that differ by one priority rank: step against maskable, debug against non-maskable, fault against debug. A wrong ordering between neighbours then shows up as a wrong code. The maskable request is held across a change of the enable flag, which separates a dropped request from one that was only gated. Privilege pairs with the current level equal to the threshold and one above it separate a strict comparison from a non-strict one. Both values of the restart flag, and decision against non-decision cycles, show whether the flag is set and cleared on the right decisions.

// File: rtl/evt_gate_pkg.sv
package evt_gate_pkg;

   localparam int NUM_EVT = 5;
   localparam int CODE_W  = $clog2(NUM_EVT + 1);

   // index into the one-hot vector, highest priority at 0
   localparam int IX_FAULT = 0;
   localparam int IX_DEBUG = 1;
   localparam int IX_NMI   = 2;
   localparam int IX_STEP  = 3;
   localparam int IX_MASK  = 4;

   typedef enum logic [CODE_W-1:0] {
      EV_NONE  = 3'd0,
      EV_FAULT = 3'd1,
      EV_DEBUG = 3'd2,
      EV_NMI   = 3'd3,
      EV_STEP  = 3'd4,
      EV_MASK  = 3'd5
   } evt_code_t;

endpackage

// File: rtl/io_perm_chk.sv
module io_perm_chk #(
   parameter int PRIV_W = 2
) (
   input  logic              io_insn_i,
   input  logic [PRIV_W-1:0] cur_lvl_i,
   input  logic [PRIV_W-1:0] io_lvl_i,
   output logic              deny_o
);

   generate
      if (PRIV_W < 1 || PRIV_W > 8) begin : g_bad_w
         $error("io_perm_chk: PRIV_W must lie in 1..8");
      end
   endgenerate

   logic above;

   always_comb begin
      above  = (cur_lvl_i > io_lvl_i);
      deny_o = io_insn_i & above;
   end

endmodule

// File: rtl/evt_prio_arb.sv
module evt_prio_arb #(
   parameter int N      = 5,
   parameter int CODE_W = $clog2(N + 1)
) (
   input  logic [N-1:0]      req_i,
   output logic [N-1:0]      gnt_o,
   output logic [CODE_W-1:0] code_o
);

   generate
      if (N < 1) begin : g_bad_n
         $error("evt_prio_arb: N must be at least 1");
      end
      if ((1 << CODE_W) < N + 1) begin : g_bad_code
         $error("evt_prio_arb: CODE_W too narrow for N");
      end
   endgenerate

   // blk[i] is set when any request above index i is present
   logic [N:0] blk;
   assign blk[0] = 1'b0;

   genvar gi;
   generate
      for (gi = 0; gi < N; gi++) begin : g_chain
         assign gnt_o[gi]   = req_i[gi] & ~blk[gi];
         assign blk[gi + 1] = blk[gi] | req_i[gi];
      end
   endgenerate

   always_comb begin
      code_o = '0;
      for (int k = 0; k < N; k++) begin
         if (gnt_o[k]) code_o = CODE_W'(k + 1);
      end
   end

endmodule

// File: rtl/ret_path_sel.sv
module ret_path_sel (
   input  logic clk,
   input  logic rst_n,
   input  logic iret_i,
   input  logic chain_flag_i,
   output logic ret_norm_o,
   output logic ret_task_o
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ret_norm_o <= 1'b0;
         ret_task_o <= 1'b0;
      end else begin
         ret_norm_o <= iret_i & ~chain_flag_i;
         ret_task_o <= iret_i &  chain_flag_i;
      end
   end

endmodule

// File: rtl/evt_gate_unit.sv
module evt_gate_unit
   import evt_gate_pkg::*;
#(
   parameter int PRIV_W = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                insn_done_i,
   input  logic                io_insn_i,
   input  logic                iret_i,
   input  logic                trap_flag_i,
   input  logic                int_en_i,
   input  logic                restart_flag_i,
   input  logic                chain_flag_i,
   input  logic [PRIV_W-1:0]   io_lvl_i,
   input  logic [PRIV_W-1:0]   cur_lvl_i,
   input  logic                req_mask_i,
   input  logic                req_nmi_i,
   input  logic                req_fault_i,
   input  logic                req_dbg_i,
   output logic [NUM_EVT-1:0]  evt_onehot_o,
   output logic [CODE_W-1:0]   evt_code_o,
   output logic                step_req_o,
   output logic                io_fault_o,
   output logic                ret_norm_o,
   output logic                ret_task_o,
   output logic                rf_o
);

   logic               io_deny;
   logic               completed;
   logic [NUM_EVT-1:0] req_vec;
   logic [NUM_EVT-1:0] gnt;
   logic [CODE_W-1:0]  gnt_code;
   logic               rf_next;

   io_perm_chk #(.PRIV_W(PRIV_W)) u_perm (
      .io_insn_i (io_insn_i),
      .cur_lvl_i (cur_lvl_i),
      .io_lvl_i  (io_lvl_i),
      .deny_o    (io_deny)
   );

   // a denied I/O access replaces completion of the instruction
   always_comb begin
      completed         = insn_done_i & ~io_deny;
      req_vec           = '0;
      req_vec[IX_FAULT] = insn_done_i & (req_fault_i | io_deny);
      req_vec[IX_DEBUG] = completed & req_dbg_i & ~restart_flag_i;
      req_vec[IX_NMI]   = completed & req_nmi_i;
      req_vec[IX_STEP]  = completed & trap_flag_i;
      req_vec[IX_MASK]  = completed & req_mask_i & int_en_i;
   end

   evt_prio_arb #(.N(NUM_EVT), .CODE_W(CODE_W)) u_arb (
      .req_i  (req_vec),
      .gnt_o  (gnt),
      .code_o (gnt_code)
   );

   always_comb begin
      rf_next = rf_o;
      if (insn_done_i) rf_next = gnt[IX_FAULT];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         evt_onehot_o <= '0;
         evt_code_o   <= '0;
         step_req_o   <= 1'b0;
         io_fault_o   <= 1'b0;
         rf_o         <= 1'b0;
      end else begin
         evt_onehot_o <= gnt;
         evt_code_o   <= gnt_code;
         step_req_o   <= completed & trap_flag_i;
         io_fault_o   <= insn_done_i & io_deny;
         rf_o         <= rf_next;
      end
   end

   ret_path_sel u_ret (
      .clk          (clk),
      .rst_n        (rst_n),
      .iret_i       (iret_i),
      .chain_flag_i (chain_flag_i),
      .ret_norm_o   (ret_norm_o),
      .ret_task_o   (ret_task_o)
   );

endmodule

// File: rtl/evt_gate_chk.sv
module evt_gate_chk
   import evt_gate_pkg::*;
#(
   parameter int PRIV_W = 2
) (
   input logic               clk,
   input logic               rst_n,
   input logic               insn_done_i,
   input logic               io_insn_i,
   input logic               iret_i,
   input logic               trap_flag_i,
   input logic               int_en_i,
   input logic               restart_flag_i,
   input logic               chain_flag_i,
   input logic [PRIV_W-1:0]  io_lvl_i,
   input logic [PRIV_W-1:0]  cur_lvl_i,
   input logic               req_nmi_i,
   input logic [NUM_EVT-1:0] evt_onehot_o,
   input logic               step_req_o,
   input logic               io_fault_o,
   input logic               ret_norm_o,
   input logic               ret_task_o,
   input logic               rf_o
);

   AST_ONE_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(evt_onehot_o)); // R8

   AST_MASK_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      evt_onehot_o[IX_MASK] |-> $past(int_en_i)); // R1

   AST_NMI_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
      (insn_done_i && req_nmi_i) |=> (evt_onehot_o != '0)); // R2

   AST_STEP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      (insn_done_i && trap_flag_i && !(io_insn_i && cur_lvl_i > io_lvl_i))
      |=> step_req_o); // R3

   AST_IO_DENY: assert property (@(posedge clk) disable iff (!rst_n)
      (insn_done_i && io_insn_i && cur_lvl_i > io_lvl_i)
      |=> (io_fault_o && evt_onehot_o[IX_FAULT] && !step_req_o)); // R4

   AST_DBG_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      (insn_done_i && restart_flag_i) |=> !evt_onehot_o[IX_DEBUG]); // R5

   AST_RF_ON_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
      io_fault_o |-> rf_o); // R6

   AST_RF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !insn_done_i |=> $stable(rf_o)); // R6

   AST_RET_TASK: assert property (@(posedge clk) disable iff (!rst_n)
      (iret_i && chain_flag_i) |=> (ret_task_o && !ret_norm_o)); // R7

   AST_RET_NORM: assert property (@(posedge clk) disable iff (!rst_n)
      (iret_i && !chain_flag_i) |=> (ret_norm_o && !ret_task_o)); // R7

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !insn_done_i |=> (evt_onehot_o == '0 && !step_req_o && !io_fault_o)); // R9

endmodule

bind evt_gate_unit evt_gate_chk #(.PRIV_W(PRIV_W)) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .insn_done_i    (insn_done_i),
   .io_insn_i      (io_insn_i),
   .iret_i         (iret_i),
   .trap_flag_i    (trap_flag_i),
   .int_en_i       (int_en_i),
   .restart_flag_i (restart_flag_i),
   .chain_flag_i   (chain_flag_i),
   .io_lvl_i       (io_lvl_i),
   .cur_lvl_i      (cur_lvl_i),
   .req_nmi_i      (req_nmi_i),
   .evt_onehot_o   (evt_onehot_o),
   .step_req_o     (step_req_o),
   .io_fault_o     (io_fault_o),
   .ret_norm_o     (ret_norm_o),
   .ret_task_o     (ret_task_o),
   .rf_o           (rf_o)
);

// File: tb/tb_evt_gate_unit.sv
module tb_evt_gate_unit;

   localparam int CLK_PERIOD = 10;
   localparam int PW         = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          insn_done = 1'b0, io_insn = 1'b0, iret = 1'b0;
   logic          trap_f = 1'b0, int_en = 1'b0, restart_f = 1'b0, chain_f = 1'b0;
   logic [PW-1:0] io_lvl = '0, cur_lvl = '0;
   logic          r_mask = 1'b0, r_nmi = 1'b0, r_fault = 1'b0, r_dbg = 1'b0;
   logic [4:0]    onehot;
   logic [2:0]    code;
   logic          step_req, io_fault, ret_norm, ret_task, rf;

   int checks = 0;
   int fails  = 0;
   bit ended  = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   evt_gate_unit #(.PRIV_W(PW)) dut (
      .clk(clk), .rst_n(rst_n), .insn_done_i(insn_done), .io_insn_i(io_insn),
      .iret_i(iret), .trap_flag_i(trap_f), .int_en_i(int_en),
      .restart_flag_i(restart_f), .chain_flag_i(chain_f), .io_lvl_i(io_lvl),
      .cur_lvl_i(cur_lvl), .req_mask_i(r_mask), .req_nmi_i(r_nmi),
      .req_fault_i(r_fault), .req_dbg_i(r_dbg), .evt_onehot_o(onehot),
      .evt_code_o(code), .step_req_o(step_req), .io_fault_o(io_fault),
      .ret_norm_o(ret_norm), .ret_task_o(ret_task), .rf_o(rf)
   );

   task automatic chk(string tag, int act, int exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // code k maps to one-hot bit k-1, code 0 to no bit
   function automatic int oh_of(int c);
      return (c == 0) ? 0 : (1 << (c - 1));
   endfunction

   task automatic chk_evt(string tag, int exp_code);
      chk({tag, " code"}, int'(code), exp_code);
      chk({tag, " onehot"}, int'(onehot), oh_of(exp_code));
   endtask

   task automatic clear_reqs();
      r_mask = 0; r_nmi = 0; r_fault = 0; r_dbg = 0;
      trap_f = 0; io_insn = 0; restart_f = 0; int_en = 0;
      cur_lvl = '0; io_lvl = '0;
   endtask

   // called at a falling edge; returns one falling edge later
   task automatic decide();
      insn_done = 1'b1;
      @(negedge clk);
      insn_done = 1'b0;
   endtask

   task automatic t_reset();
      chk("R10 evt", int'(onehot), 0);
      chk("R10 step", int'(step_req), 0);
      chk("R10 iofault", int'(io_fault), 0);
      chk("R10 ret", int'(ret_norm | ret_task), 0);
      chk("R10 rf", int'(rf), 0);
   endtask

   task automatic t_mask();
      clear_reqs();
      r_mask = 1; int_en = 0;
      decide();
      chk_evt("R1 masked", 0);
      int_en = 1;
      decide();
      chk_evt("R1 enabled", 5);
      clear_reqs();
   endtask

   task automatic t_nmi_fault();
      clear_reqs();
      r_nmi = 1;
      decide();
      chk_evt("R2 nmi", 3);
      chk("R6 rf after nmi", int'(rf), 0);
      r_nmi = 0; r_fault = 1;
      decide();
      chk_evt("R2 fault", 1);
      chk("R6 rf set", int'(rf), 1);
      clear_reqs();
      @(negedge clk);
      chk("R9 idle evt", int'(onehot), 0);
      chk("R6 rf hold", int'(rf), 1);
   endtask

   task automatic t_step();
      clear_reqs();
      trap_f = 1;
      decide();
      chk_evt("R3 step", 4);
      chk("R3 step_req", int'(step_req), 1);
      chk("R6 rf clear", int'(rf), 0);
      r_mask = 1; int_en = 1;
      decide();
      chk_evt("R8 step over mask", 4);
      r_fault = 1;
      decide();
      chk_evt("R8 fault over step", 1);
      chk("R3 step_req with fault", int'(step_req), 1);
      clear_reqs();
   endtask

   task automatic t_io();
      clear_reqs();
      io_insn = 1; cur_lvl = 2'd2; io_lvl = 2'd2;
      decide();
      chk("R4 equal allowed", int'(io_fault), 0);
      chk_evt("R4 equal", 0);
      cur_lvl = 2'd3; trap_f = 1;
      decide();
      chk("R4 above denied", int'(io_fault), 1);
      chk_evt("R4 denied", 1);
      chk("R4 no step", int'(step_req), 0);
      chk("R6 rf io", int'(rf), 1);
      cur_lvl = 2'd0; io_lvl = 2'd1; trap_f = 0;
      decide();
      chk("R4 below allowed", int'(io_fault), 0);
      clear_reqs();
   endtask

   task automatic t_debug();
      clear_reqs();
      r_dbg = 1; restart_f = 1;
      decide();
      chk_evt("R5 rejected", 0);
      restart_f = 0;
      decide();
      chk_evt("R5 accepted", 2);
      chk("R6 rf debug", int'(rf), 0);
      r_nmi = 1;
      decide();
      chk_evt("R8 debug over nmi", 2);
      restart_f = 1;
      decide();
      chk_evt("R8 nmi when debug blocked", 3);
      restart_f = 0; r_fault = 1;
      decide();
      chk_evt("R8 fault over debug", 1);
      clear_reqs();
   endtask

   task automatic t_idle();
      clear_reqs();
      r_nmi = 1; r_fault = 1; trap_f = 1;
      @(negedge clk);
      chk_evt("R9 no strobe", 0);
      chk("R9 no step", int'(step_req), 0);
      clear_reqs();
   endtask

   task automatic t_ret();
      chain_f = 0; iret = 1;
      @(negedge clk);
      iret = 0;
      chk("R7 normal", int'(ret_norm), 1);
      chk("R7 normal task", int'(ret_task), 0);
      chain_f = 1; iret = 1;
      @(negedge clk);
      iret = 0;
      chk("R7 task", int'(ret_task), 1);
      chk("R7 task normal", int'(ret_norm), 0);
      @(negedge clk);
      chk("R7 pulse end", int'(ret_task), 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_mask();
      t_nmi_fault();
      t_step();
      t_io();
      t_debug();
      t_idle();
      t_ret();
      if (!ended) begin
         ended = 1'b1;
         $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!ended) begin
         ended = 1'b1;
         checks++;
         fails++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule